// File: doc/BRIEF.md
# ADC Power Mode Controller

This block manages the power state of a serial sampling converter. It samples the serial clock, the conversion-start strobe and an active-low shutdown pin on a fast system clock. From these it picks one of four states: active, nap, sleep or shutdown. It drives enables for the comparator, the reference and the converter core. It also keeps a reference-ready flag that a serializer later sends in front of each data word. A parameterised cycle counter stands in for the analog settling time of the reference.

The host reaches the low-power states through a fixed gesture. It holds the serial clock low and pulses the conversion-start strobe. The second consecutive pulse selects nap and the fourth selects sleep. A serial clock high pulse of at least a set length wakes the block again. The shutdown pin overrides everything else.

There is no data stream through this block. Every pin is a plain level that is sampled on each rising edge of `clk`, so the block has no handshake or back-pressure.

Top module: `adc_pwr_ctrl`

## Requirements
- R1: After reset the status output `pwr_state` is 0 (encoding 0=active, 1=nap, 2=sleep, 3=shutdown). `comp_en`, `ref_en` and `core_en` are all 1, and `ref_rdy` is 1.
- R2: In active, two conversion-start falling edges sampled while `sclk` is low move the block to nap. In nap only `ref_en` is 1, and `ref_rdy` is unchanged.
- R3: The change to nap or sleep happens at the clock edge that first samples `conv` low after the last counted pulse. While that pulse is still high the state is unchanged.
- R4: The fourth consecutive qualifying falling edge moves the block to sleep. This holds whether the pulses are counted from active or continued in nap. In sleep all three enables are 0 and `ref_rdy` is 0.
- R5: In nap or sleep, `sclk` sampled high on WAKE_CYC consecutive edges returns the block to active with all enables at 1. A shorter high pulse leaves the state unchanged.
- R6: `shdn_n` sampled low forces shutdown at that edge. In shutdown all enables are 0, `ref_rdy` is 0, and strobes and clock pulses have no effect. `shdn_n` sampled high in shutdown returns the block to active.
- R7: After a return to active from sleep or shutdown, `ref_rdy` stays 0 for SETTLE_CYC-1 further edges. It becomes 1 at the SETTLE_CYC-th edge after the return.
- R8: A return to active from nap keeps `ref_rdy` at 1.
- R9: A rising edge of `sclk` clears the pulse count. Only pulses with no serial clock edge between them count toward nap or sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock level, sampled on clk |
| conv | input | 1 | Conversion-start strobe level, sampled on clk |
| shdn_n | input | 1 | Active-low shutdown request |
| comp_en | output | 1 | Comparator power enable |
| ref_en | output | 1 | Reference power enable |
| core_en | output | 1 | Converter core enable |
| ref_rdy | output | 1 | Reference-ready flag for the serial word |
| pwr_state | output | 2 | Current state: 0 active, 1 nap, 2 sleep, 3 shutdown |

## Verification
The hardest case is a pulse count that a short serial clock blip has interrupted while the block is already in nap. In that case the nap threshold must not fire again, and the count must restart from zero toward sleep. The stimulus covers this in two steps. It first enters nap. It then applies a clock pulse one edge shorter than the wake length, so the block stays in nap. Finally it sends two pairs of strobes and expects nap after the first pair and sleep after the second. The wake length is also swept on each side of the threshold from both nap and sleep, and the ready flag is timed edge by edge after each kind of wake.

// File: rtl/adc_pwr_ctrl_pkg.sv
package adc_pwr_ctrl_pkg;
  typedef enum logic [1:0] {
    PS_ACTIVE = 2'd0,
    PS_NAP    = 2'd1,
    PS_SLEEP  = 2'd2,
    PS_SHUT   = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/pwr_pulse_counter.sv
module pwr_pulse_counter #(
  parameter int NAP_PULSES   = 2,
  parameter int SLEEP_PULSES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_fall,
  input  logic sclk_rise,
  input  logic sclk_lvl,
  input  logic count_en,
  input  logic clr,
  output logic nap_hit,
  output logic sleep_hit
);
  localparam int CW = $clog2(SLEEP_PULSES + 1);
  localparam logic [CW-1:0] NAP_V   = CW'(NAP_PULSES);
  localparam logic [CW-1:0] SLEEP_V = CW'(SLEEP_PULSES);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;
  logic          qualify;

  assign qualify = count_en && conv_fall && !sclk_lvl;
  assign cnt_inc = (cnt_q == SLEEP_V) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (clr || sclk_rise)
      cnt_q <= '0;
    else if (qualify)
      cnt_q <= cnt_inc;
  end

  assign nap_hit   = qualify && (cnt_inc == NAP_V);
  assign sleep_hit = qualify && (cnt_inc == SLEEP_V);
endmodule

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
  parameter int WAKE_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_lvl,
  output logic wake
);
  localparam int HW = $clog2(WAKE_CYC + 1);
  localparam logic [HW-1:0] FULL_V = HW'(WAKE_CYC);
  localparam logic [HW-1:0] LAST_V = HW'(WAKE_CYC - 1);

  logic [HW-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hi_q <= '0;
    else if (!sclk_lvl)
      hi_q <= '0;
    else if (hi_q != FULL_V)
      hi_q <= hi_q + 1'b1;
  end

  assign wake = sclk_lvl && (hi_q == LAST_V);
endmodule

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
  parameter int SETTLE_CYC = 300000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_off,
  input  logic load,
  output logic ready
);
  localparam int TW = $clog2(SETTLE_CYC + 1);
  localparam logic [TW-1:0] LOAD_V = TW'(SETTLE_CYC);
  localparam logic [TW-1:0] ONE_V  = TW'(1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ready <= 1'b1;
    end else if (hold_off) begin
      cnt_q <= '0;
      ready <= 1'b0;
    end else if (load) begin
      cnt_q <= LOAD_V;
      ready <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == ONE_V)
        ready <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_pwr_ctrl.sv
module adc_pwr_ctrl
  import adc_pwr_ctrl_pkg::*;
#(
  parameter int NAP_PULSES   = 2,
  parameter int SLEEP_PULSES = 4,
  parameter int WAKE_CYC     = 6,
  parameter int SETTLE_CYC   = 300000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       conv,
  input  logic       shdn_n,
  output logic       comp_en,
  output logic       ref_en,
  output logic       core_en,
  output logic       ref_rdy,
  output logic [1:0] pwr_state
);
  pwr_state_e state_q, state_nx;
  logic sclk_q, conv_q;
  logic sclk_rise, conv_fall;
  logic nap_hit, sleep_hit, wake;
  logic cnt_en, cnt_clr;
  logic nx_dark, cur_dark;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      conv_q <= 1'b0;
    end else begin
      sclk_q <= sclk;
      conv_q <= conv;
    end
  end

  assign sclk_rise = sclk && !sclk_q;
  assign conv_fall = conv_q && !conv;

  always_comb begin
    state_nx = state_q;
    if (!shdn_n) begin
      state_nx = PS_SHUT;
    end else begin
      case (state_q)
        PS_SHUT:   state_nx = PS_ACTIVE;
        PS_ACTIVE: begin
          if (sleep_hit)    state_nx = PS_SLEEP;
          else if (nap_hit) state_nx = PS_NAP;
        end
        PS_NAP: begin
          if (wake)           state_nx = PS_ACTIVE;
          else if (sleep_hit) state_nx = PS_SLEEP;
        end
        PS_SLEEP: if (wake) state_nx = PS_ACTIVE;
        default:  state_nx = PS_ACTIVE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_ACTIVE;
    else        state_q <= state_nx;
  end

  assign cnt_en   = (state_q == PS_ACTIVE) || (state_q == PS_NAP);
  assign cur_dark = (state_q == PS_SLEEP) || (state_q == PS_SHUT);
  assign nx_dark  = (state_nx == PS_SLEEP) || (state_nx == PS_SHUT);
  assign cnt_clr  = cur_dark || (state_nx == PS_SHUT);

  pwr_pulse_counter #(
    .NAP_PULSES  (NAP_PULSES),
    .SLEEP_PULSES(SLEEP_PULSES)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .conv_fall(conv_fall),
    .sclk_rise(sclk_rise),
    .sclk_lvl (sclk),
    .count_en (cnt_en),
    .clr      (cnt_clr),
    .nap_hit  (nap_hit),
    .sleep_hit(sleep_hit)
  );

  pwr_wake_detect #(
    .WAKE_CYC(WAKE_CYC)
  ) u_wake (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_lvl(sclk),
    .wake    (wake)
  );

  pwr_settle_timer #(
    .SETTLE_CYC(SETTLE_CYC)
  ) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_off(nx_dark),
    .load    (cur_dark && (state_nx == PS_ACTIVE)),
    .ready   (ref_rdy)
  );

  assign comp_en   = (state_q == PS_ACTIVE);
  assign core_en   = (state_q == PS_ACTIVE);
  assign ref_en    = (state_q == PS_ACTIVE) || (state_q == PS_NAP);
  assign pwr_state = state_q;
endmodule

// File: rtl/adc_pwr_ctrl_chk.sv
module adc_pwr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk,
  input logic       conv,
  input logic       shdn_n,
  input logic       comp_en,
  input logic       ref_en,
  input logic       core_en,
  input logic       ref_rdy,
  input logic [1:0] pwr_state
);
  AST_SHDN_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |=> (pwr_state == 2'd3) && !ref_rdy && !comp_en && !ref_en); // R6

  AST_SLEEP_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd2) |-> !ref_rdy && !comp_en && !core_en); // R4

  AST_NAP_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_state) == 2'd0 && pwr_state == 2'd1)
      |-> ($past(conv, 2) && !$past(conv) && !$past(sclk))); // R3

  AST_WAKE_NEEDS_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pwr_state) == 2'd1 || $past(pwr_state) == 2'd2) && pwr_state == 2'd0)
      |-> $past(sclk)); // R5

  AST_DARK_WAKE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pwr_state) == 2'd2 || $past(pwr_state) == 2'd3) && pwr_state == 2'd0)
      |-> !ref_rdy); // R7

  AST_NAP_WAKE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_state) == 2'd1 && pwr_state == 2'd0 && $past(ref_rdy))
      |-> ref_rdy); // R8

  AST_NAP_REF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd1) |-> ref_en && !comp_en && !core_en); // R2
endmodule

bind adc_pwr_ctrl adc_pwr_ctrl_chk u_chk (.*);

// File: tb/adc_pwr_ctrl_tb.sv
module adc_pwr_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WAKE_CYC   = 3;
  localparam int SETTLE_CYC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic conv = 1'b0;
  logic shdn_n = 1'b1;
  logic comp_en, ref_en, core_en, ref_rdy;
  logic [1:0] pwr_state;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_pwr_ctrl #(
    .WAKE_CYC  (WAKE_CYC),
    .SETTLE_CYC(SETTLE_CYC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .conv(conv), .shdn_n(shdn_n),
    .comp_en(comp_en), .ref_en(ref_en), .core_en(core_en),
    .ref_rdy(ref_rdy), .pwr_state(pwr_state)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int en_of(input int st);
    case (st)
      0: return 7;
      1: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic int en_now();
    return {comp_en, ref_en, core_en};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sclk = 1'b0; conv = 1'b0; shdn_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic conv_pulse();
    conv = 1'b1;
    @(negedge clk);
    conv = 1'b0;
    @(negedge clk);
  endtask

  task automatic sclk_pulse(input int n);
    sclk = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic ready_timing(input string req);
    check({req, " ready low at return"}, ref_rdy, 0);
    repeat (SETTLE_CYC - 1) @(negedge clk);
    check({req, " ready low one edge before"}, ref_rdy, 0);
    @(negedge clk);
    check({req, " ready high at settle"}, ref_rdy, 1);
  endtask

  initial begin
    do_reset();
    check("R1 state", pwr_state, 0);
    check("R1 enables", en_now(), 7);
    check("R1 ready", ref_rdy, 1);

    // R2 R4: pulse count sweep from active
    for (int n = 1; n <= 6; n++) begin
      int exp_st;
      do_reset();
      for (int k = 1; k <= n; k++) conv_pulse();
      exp_st = (n >= 4) ? 2 : (n >= 2) ? 1 : 0;
      check(n >= 4 ? "R4 state" : "R2 state", pwr_state, exp_st);
      check(n >= 4 ? "R4 enables" : "R2 enables", en_now(), en_of(exp_st));
      check(n >= 4 ? "R4 ready" : "R2 ready", ref_rdy, (n >= 4) ? 0 : 1);
    end

    // R3: change lands on the falling edge, not before
    do_reset();
    conv_pulse();
    conv = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R3 held while high", pwr_state, 0);
    conv = 1'b0;
    @(negedge clk);
    check("R3 nap at fall", pwr_state, 1);
    conv_pulse();
    conv = 1'b1;
    @(negedge clk);
    check("R3 nap while fourth high", pwr_state, 1);
    conv = 1'b0;
    @(negedge clk);
    check("R3 sleep at fall", pwr_state, 2);

    // R5 R7 R8: wake length sweep from nap and sleep
    for (int lp = 0; lp < 2; lp++) begin
      for (int len = 1; len <= WAKE_CYC + 2; len++) begin
        int low_st;
        low_st = (lp == 0) ? 1 : 2;
        do_reset();
        for (int k = 0; k < 2 * (lp + 1); k++) conv_pulse();
        sclk_pulse(len);
        @(negedge clk);
        if (len >= WAKE_CYC) begin
          check("R5 woke", pwr_state, 0);
          check("R5 enables", en_now(), 7);
          if (lp == 0) check("R8 nap wake ready", ref_rdy, 1);
          else         check("R7 sleep wake ready", ref_rdy, (len - WAKE_CYC + 1 >= SETTLE_CYC) ? 1 : 0);
        end else begin
          check("R5 short pulse ignored", pwr_state, low_st);
        end
      end
    end

    // R9: clock edge between pulses restarts the count (active)
    do_reset();
    conv_pulse();
    sclk_pulse(1);
    @(negedge clk);
    conv_pulse();
    check("R9 active interrupted", pwr_state, 0);
    conv_pulse();
    check("R9 active recount", pwr_state, 1);

    // R9: in nap, a short blip restarts the count toward sleep
    do_reset();
    conv_pulse(); conv_pulse();
    sclk_pulse(WAKE_CYC - 1);
    @(negedge clk);
    check("R9 nap after blip", pwr_state, 1);
    conv_pulse(); conv_pulse();
    check("R9 nap two after blip", pwr_state, 1);
    conv_pulse(); conv_pulse();
    check("R9 sleep four after blip", pwr_state, 2);

    // R7: exact ready timing after sleep wake
    do_reset();
    repeat (4) conv_pulse();
    sclk_pulse(WAKE_CYC);
    check("R7 state after wake", pwr_state, 0);
    ready_timing("R7 sleep");

    // R6: shutdown from active, stimulus ignored, release
    do_reset();
    shdn_n = 1'b0;
    @(negedge clk);
    check("R6 state", pwr_state, 3);
    check("R6 enables", en_now(), 0);
    check("R6 ready", ref_rdy, 0);
    repeat (4) conv_pulse();
    sclk_pulse(WAKE_CYC + 1);
    @(negedge clk);
    check("R6 stays shut", pwr_state, 3);
    shdn_n = 1'b1;
    @(negedge clk);
    check("R6 release active", pwr_state, 0);
    check("R6 release enables", en_now(), 7);
    ready_timing("R7 shutdown");
    conv_pulse(); conv_pulse();
    check("R6 pulses in shutdown not counted", pwr_state, 1);

    // R6: shutdown overrides nap
    do_reset();
    conv_pulse(); conv_pulse();
    shdn_n = 1'b0;
    @(negedge clk);
    check("R6 from nap", pwr_state, 3);
    check("R6 from nap ready", ref_rdy, 0);
    shdn_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule